// File: doc/BRIEF.md
# Privilege-Filtered Performance Event Counter Bank

This block holds a small bank of programmable performance counters for one hart. Each counter has a 64-bit count and a 64-bit event-control register. The top six bits of the event-control register are a sticky overflow flag and five inhibit bits, one for each privilege context. Each cycle, a counter's increment strobe is qualified by three things. The global inhibit mask can block it. The current privilege and virtualization state can block it, through a five-way check against the counter's own inhibit bits. A software write to the same count also blocks it.

The core can view the counters in a 64-bit arrangement or in a 32-bit arrangement. In the 32-bit arrangement the count and the event-control register each split into a low and a high register, so the inhibit and overflow bits sit in the high event register. A counter wraps only when the full 64-bit value is all ones. If its overflow flag was clear at that moment, the flag is set and a level interrupt request is raised. The request is held by a two-state controller: IRQ_IDLE moves to IRQ_PEND on any new overflow, and IRQ_PEND returns to IRQ_IDLE when software clears it and no new overflow arrives in that same cycle.

Software reaches every register through a simple indexed port. A write takes effect at the clock edge. A read is combinational.

Top module: `pmc_bank`

## Requirements
- R1: After reset, every count and event-control register reads zero and `ovf_irq` is low.
- R2: With `priv` = 2'b11 (machine), a counter whose event bit 62 is set does not count; other privilege levels are not affected by that bit.
- R3: With `priv` = 2'b01 (supervisor), bit 59 blocks counting when `virt` is 1 and bit 61 blocks counting when `virt` is 0.
- R4: With `priv` = 2'b00 (user), bit 58 blocks counting when `virt` is 1 and bit 60 blocks counting when `virt` is 0. The reserved level 2'b10 is never inhibited.
- R5: A counter whose bit in `inh_mask` is set does not count, whatever its strobe.
- R6: A qualified strobe adds one to the count, visible from the next cycle. A count of all ones wraps to zero. Without a strobe the count holds.
- R7: With `mode32` = 1, the low half increments until it is all ones. After that, each increment adds one to the high half and leaves the low half at all ones. When both halves are all ones, an increment clears both.
- R8: Register select codes are 0 count, 1 count-high, 2 event, 3 event-high. With `mode32` = 1, codes 0 and 2 access bits 31:0 and codes 1 and 3 access bits 63:32, all through data bits 31:0; event-high bit 31 is the overflow flag and bits 30..26 are the inhibit bits. With `mode32` = 0, codes 0 and 2 access all 64 bits, writes with codes 1 and 3 are ignored, and reads with codes 1 and 3 return zero.
- R9: A wrap with the overflow flag (event bit 63) clear sets the flag and raises `ovf_irq`. A wrap with the flag already set leaves it set and raises no new request. The flag changes only by wrap or by event write.
- R10: `ovf_irq` stays high until `irq_clear` is asserted. A clear in the same cycle as a new overflow leaves it high.
- R11: Writing the overflow flag back to zero re-arms it, so the next wrap raises `ovf_irq` again.
- R12: A count write and a qualified strobe to the same counter in the same cycle leave the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode32 | input | 1 | 1 selects the split 32-bit register view and increment rule |
| priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine, 10 reserved |
| virt | input | 1 | Hart runs in a virtualized context |
| inh_mask | input | NUM_CTR | Global per-counter count inhibit |
| evt_strobe | input | NUM_CTR | Per-counter event occurrence this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Counter addressed by the write |
| wr_sel | input | 2 | Register addressed by the write |
| wr_data | input | 64 | Write data |
| rd_idx | input | IDX_W | Counter addressed by the read |
| rd_sel | input | 2 | Register addressed by the read |
| rd_data | output | 64 | Combinational read data |
| irq_clear | input | 1 | Software clear of the pending overflow request |
| ovf_irq | output | 1 | Local counter-overflow interrupt request |

## Verification
Several properties are checked on every cycle: the count holds whenever the mask, a machine-mode inhibit or an idle strobe should freeze it; a same-cycle count write always lands; the overflow flag never drops without an event write; and the request rises after every fresh overflow, persists until cleared and falls after a clear with no new overflow. Only the bench scenarios can show the arithmetic itself. That covers the split-half increment that holds the low half at all ones, the exact wrap boundary, and the placement of the control bits in the high event register. The same holds for the supervisor and user inhibit selection under each virtualization state, and for the ignored high-half accesses in 64-bit mode. A behavioural model compares the read port and the request line on every clock.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int CNT_W  = 64;
    localparam int HALF_W = CNT_W / 2;

    // Control bit positions inside the 64-bit event-control register
    localparam int EV_OF    = 63;
    localparam int EV_MINH  = 62;
    localparam int EV_SINH  = 61;
    localparam int EV_UINH  = 60;
    localparam int EV_VSINH = 59;
    localparam int EV_VUINH = 58;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        SEL_CNT  = 2'd0,
        SEL_CNTH = 2'd1,
        SEL_EVT  = 2'd2,
        SEL_EVTH = 2'd3
    } regsel_e;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_st_e;

    typedef struct packed {
        logic minh;
        logic sinh;
        logic uinh;
        logic vsinh;
        logic vuinh;
    } inh_bits_t;
endpackage

// File: rtl/pmc_filter.sv
module pmc_filter
    import pmc_pkg::*;
(
    input  logic [1:0]  priv,
    input  logic        virt,
    input  inh_bits_t   inh,
    output logic        allow
);
    always_comb begin
        allow = 1'b1;
        unique case (priv_e'(priv))
            PRIV_M:   allow = !inh.minh;
            PRIV_S:   allow = virt ? !inh.vsinh : !inh.sinh;
            PRIV_U:   allow = virt ? !inh.vuinh : !inh.uinh;
            PRIV_RSV: allow = 1'b1;
            default:  allow = 1'b1;
        endcase
    end
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode32,
    input  logic [1:0]        priv,
    input  logic              virt,
    input  logic              strobe,
    input  logic              gmask,
    input  logic              wr_cnt_lo,
    input  logic              wr_cnt_hi,
    input  logic              wr_evt_lo,
    input  logic              wr_evt_hi,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  evt_q,
    output logic              ovf_new
);
    logic [CNT_W-1:0]  cnt_d;
    logic [CNT_W-1:0]  evt_d;
    logic [HALF_W-1:0] lo;
    logic [HALF_W-1:0] hi;
    logic [HALF_W-1:0] hi_src;
    logic              lo_full;
    logic              hi_full;
    logic              cnt_wr;
    logic              evt_wr;
    logic              allow;
    logic              bump;
    logic              wrap;
    inh_bits_t         inh;

    assign inh = '{minh:  evt_q[EV_MINH],
                   sinh:  evt_q[EV_SINH],
                   uinh:  evt_q[EV_UINH],
                   vsinh: evt_q[EV_VSINH],
                   vuinh: evt_q[EV_VUINH]};

    pmc_filter u_filter (
        .priv  (priv),
        .virt  (virt),
        .inh   (inh),
        .allow (allow)
    );

    always_comb begin
        lo      = cnt_q[HALF_W-1:0];
        hi      = cnt_q[CNT_W-1:HALF_W];
        lo_full = &lo;
        hi_full = &hi;
        hi_src  = mode32 ? wr_data[HALF_W-1:0] : wr_data[CNT_W-1:HALF_W];
        cnt_wr  = wr_cnt_lo | wr_cnt_hi;
        evt_wr  = wr_evt_lo | wr_evt_hi;
        bump    = strobe & ~gmask & allow & ~cnt_wr;
        wrap    = bump & lo_full & hi_full;
        ovf_new = wrap & ~evt_q[EV_OF];
    end

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_wr) begin
            if (wr_cnt_lo) cnt_d[HALF_W-1:0]     = wr_data[HALF_W-1:0];
            if (wr_cnt_hi) cnt_d[CNT_W-1:HALF_W] = hi_src;
        end else if (bump) begin
            if (wrap) begin
                cnt_d = '0;
            end else if (mode32) begin
                if (!lo_full) cnt_d[HALF_W-1:0]     = lo + 1'b1;
                else          cnt_d[CNT_W-1:HALF_W] = hi + 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        evt_d = evt_q;
        if (evt_wr) begin
            if (wr_evt_lo) evt_d[HALF_W-1:0]     = wr_data[HALF_W-1:0];
            if (wr_evt_hi) evt_d[CNT_W-1:HALF_W] = hi_src;
        end else if (wrap) begin
            evt_d[EV_OF] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            evt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            evt_q <= evt_d;
        end
    end
endmodule

// File: rtl/pmc_irq_fsm.sv
module pmc_irq_fsm
    import pmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_any,
    input  logic irq_clear,
    output logic irq
);
    irq_st_e state_q;
    irq_st_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (ovf_any)                 state_d = IRQ_PEND;
            IRQ_PEND: if (irq_clear && !ovf_any)   state_d = IRQ_IDLE;
            default:                               state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_PEND);
    end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
    import pmc_pkg::*;
#(
    parameter  int NUM_CTR = 4,
    localparam int IDX_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode32,
    input  logic [1:0]         priv,
    input  logic               virt,
    input  logic [NUM_CTR-1:0] inh_mask,
    input  logic [NUM_CTR-1:0] evt_strobe,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [1:0]         wr_sel,
    input  logic [63:0]        wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [1:0]         rd_sel,
    output logic [63:0]        rd_data,
    input  logic               irq_clear,
    output logic               ovf_irq
);
    logic [NUM_CTR-1:0][CNT_W-1:0] cnt_arr;
    logic [NUM_CTR-1:0][CNT_W-1:0] evt_arr;
    logic [NUM_CTR-1:0]            ovf_vec;
    logic                          ovf_any;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic hit;
        logic w_cl, w_ch, w_el, w_eh;

        always_comb begin
            hit  = wr_en && (wr_idx == IDX_W'(i));
            w_cl = hit && (regsel_e'(wr_sel) == SEL_CNT);
            w_ch = hit && (mode32 ? (regsel_e'(wr_sel) == SEL_CNTH)
                                  : (regsel_e'(wr_sel) == SEL_CNT));
            w_el = hit && (regsel_e'(wr_sel) == SEL_EVT);
            w_eh = hit && (mode32 ? (regsel_e'(wr_sel) == SEL_EVTH)
                                  : (regsel_e'(wr_sel) == SEL_EVT));
        end

        pmc_counter u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode32    (mode32),
            .priv      (priv),
            .virt      (virt),
            .strobe    (evt_strobe[i]),
            .gmask     (inh_mask[i]),
            .wr_cnt_lo (w_cl),
            .wr_cnt_hi (w_ch),
            .wr_evt_lo (w_el),
            .wr_evt_hi (w_eh),
            .wr_data   (wr_data),
            .cnt_q     (cnt_arr[i]),
            .evt_q     (evt_arr[i]),
            .ovf_new   (ovf_vec[i])
        );
    end

    assign ovf_any = |ovf_vec;

    pmc_irq_fsm u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf_any   (ovf_any),
        .irq_clear (irq_clear),
        .irq       (ovf_irq)
    );

    always_comb begin
        rd_data = '0;
        unique case (regsel_e'(rd_sel))
            SEL_CNT:  rd_data = mode32 ? {{HALF_W{1'b0}}, cnt_arr[rd_idx][HALF_W-1:0]}
                                       : cnt_arr[rd_idx];
            SEL_CNTH: rd_data = mode32 ? {{HALF_W{1'b0}}, cnt_arr[rd_idx][CNT_W-1:HALF_W]}
                                       : '0;
            SEL_EVT:  rd_data = mode32 ? {{HALF_W{1'b0}}, evt_arr[rd_idx][HALF_W-1:0]}
                                       : evt_arr[rd_idx];
            SEL_EVTH: rd_data = mode32 ? {{HALF_W{1'b0}}, evt_arr[rd_idx][CNT_W-1:HALF_W]}
                                       : '0;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pmc_bank_chk.sv
module pmc_bank_chk
    import pmc_pkg::*;
#(
    parameter  int NUM_CTR = 4,
    localparam int IDX_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          mode32,
    input logic [1:0]                    priv,
    input logic [NUM_CTR-1:0]            inh_mask,
    input logic [NUM_CTR-1:0]            evt_strobe,
    input logic                          wr_en,
    input logic [IDX_W-1:0]              wr_idx,
    input logic [1:0]                    wr_sel,
    input logic [63:0]                   wr_data,
    input logic                          irq_clear,
    input logic                          ovf_irq,
    input logic                          ovf_any,
    input logic [NUM_CTR-1:0][CNT_W-1:0] cnt_arr,
    input logic [NUM_CTR-1:0][CNT_W-1:0] evt_arr
);
    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_any |=> ovf_irq);

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq && !irq_clear |=> ovf_irq);

    // R10
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq && irq_clear && !ovf_any |=> !ovf_irq);

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
        logic cnt_wr;
        logic evt_wr;
        assign cnt_wr = wr_en && (wr_idx == IDX_W'(i)) && (wr_sel == 2'd0 || wr_sel == 2'd1);
        assign evt_wr = wr_en && (wr_idx == IDX_W'(i)) && (wr_sel == 2'd2 || wr_sel == 2'd3);

        // R5
        mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            inh_mask[i] && !cnt_wr |=> $stable(cnt_arr[i]));

        // R6
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !evt_strobe[i] && !cnt_wr |=> $stable(cnt_arr[i]));

        // R2
        machine_inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
            priv == 2'b11 && evt_arr[i][EV_MINH] && !cnt_wr |=> $stable(cnt_arr[i]));

        // R9
        of_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_arr[i][EV_OF] && !evt_wr |=> evt_arr[i][EV_OF]);

        // R12
        wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_idx == IDX_W'(i) && wr_sel == 2'd0 && !mode32
            |=> cnt_arr[i] == $past(wr_data));
    end
endmodule

bind pmc_bank pmc_bank_chk #(.NUM_CTR(NUM_CTR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode32     (mode32),
    .priv       (priv),
    .inh_mask   (inh_mask),
    .evt_strobe (evt_strobe),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .irq_clear  (irq_clear),
    .ovf_irq    (ovf_irq),
    .ovf_any    (ovf_any),
    .cnt_arr    (cnt_arr),
    .evt_arr    (evt_arr)
);

// File: tb/tb_pmc_bank.sv
`timescale 1ns/1ps
module tb_pmc_bank;
    localparam int N = 4;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode32 = 1'b0;
    logic [1:0]  priv = 2'b11;
    logic        virt = 1'b0;
    logic [N-1:0] inh_mask = '0;
    logic [N-1:0] evt_strobe = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [1:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_idx = '0;
    logic [1:0]  rd_sel = '0;
    logic [63:0] rd_data;
    logic        irq_clear = 1'b0;
    logic        ovf_irq;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    logic [63:0] m_cnt [N];
    logic [63:0] m_evt [N];
    bit          m_irq;

    always #5 clk = ~clk;

    pmc_bank #(.NUM_CTR(N)) dut (
        .clk(clk), .rst_n(rst_n), .mode32(mode32), .priv(priv), .virt(virt),
        .inh_mask(inh_mask), .evt_strobe(evt_strobe),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_clear(irq_clear), .ovf_irq(ovf_irq)
    );

    function automatic bit blocked(logic [63:0] e);
        if (priv == 2'b11) return e[62];
        if (priv == 2'b01) return virt ? e[59] : e[61];
        if (priv == 2'b00) return virt ? e[58] : e[60];
        return 1'b0;
    endfunction

    function automatic logic [63:0] m_read(int idx, int sel);
        logic [63:0] c = m_cnt[idx];
        logic [63:0] e = m_evt[idx];
        if (mode32) begin
            case (sel)
                0: return {32'd0, c[31:0]};
                1: return {32'd0, c[63:32]};
                2: return {32'd0, e[31:0]};
                default: return {32'd0, e[63:32]};
            endcase
        end
        if (sel == 0) return c;
        if (sel == 2) return e;
        return 64'd0;
    endfunction

    task automatic model_update();
        bit any_ovf = 0;
        for (int i = 0; i < N; i++) begin
            bit cw = wr_en && wr_idx == i && (wr_sel == 0 || wr_sel == 1);
            bit ew = wr_en && wr_idx == i && (wr_sel == 2 || wr_sel == 3);
            bit go = evt_strobe[i] && !inh_mask[i] && !blocked(m_evt[i]) && !cw;
            bit wrapped = 0;
            logic [63:0] nc = m_cnt[i];
            logic [63:0] ne = m_evt[i];
            if (cw) begin
                if (!mode32 && wr_sel == 0) nc = wr_data;
                else if (mode32 && wr_sel == 0) nc[31:0] = wr_data[31:0];
                else if (mode32) nc[63:32] = wr_data[31:0];
            end else if (go) begin
                if (m_cnt[i] == ONES) begin nc = 0; wrapped = 1; end
                else if (mode32 && m_cnt[i][31:0] == 32'hFFFF_FFFF) nc = m_cnt[i] + 64'h1_0000_0000;
                else nc = m_cnt[i] + 1;
            end
            if (ew) begin
                if (!mode32 && wr_sel == 2) ne = wr_data;
                else if (mode32 && wr_sel == 2) ne[31:0] = wr_data[31:0];
                else if (mode32) ne[63:32] = wr_data[31:0];
            end else if (wrapped) ne[63] = 1'b1;
            if (wrapped && !m_evt[i][63]) any_ovf = 1;
            m_cnt[i] = nc;
            m_evt[i] = ne;
        end
        if (any_ovf) m_irq = 1;
        else if (irq_clear) m_irq = 0;
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk({cur_req, " irq"}, {63'd0, ovf_irq}, {63'd0, m_irq});
        chk({cur_req, " rd"}, rd_data, m_read(rd_idx, rd_sel));
    endtask

    task automatic wr(int idx, int sel, logic [63:0] d);
        wr_en = 1; wr_idx = idx[1:0]; wr_sel = sel[1:0]; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic pulse(int idx, int n);
        evt_strobe[idx] = 1'b1;
        repeat (n) tick();
        evt_strobe[idx] = 1'b0;
    endtask

    task automatic rd_chk(string req, int idx, int sel, logic [63:0] exp);
        rd_idx = idx[1:0]; rd_sel = sel[1:0];
        #1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_evt[i] = 0; end
        m_irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cur_req = "R1";
        chk("R1 irq", {63'd0, ovf_irq}, 64'd0);
        for (int i = 0; i < N; i++) begin
            rd_chk("R1", i, 0, 64'd0);
            rd_chk("R1", i, 2, 64'd0);
        end

        // R6 plain counting in 64-bit view
        cur_req = "R6"; priv = 2'b11;
        pulse(0, 3);
        rd_chk("R6", 0, 0, 64'd3);

        // R2 machine inhibit
        cur_req = "R2";
        wr(0, 2, 64'h4000_0000_0000_0000);
        pulse(0, 2);
        rd_chk("R2", 0, 0, 64'd3);
        priv = 2'b01;
        pulse(0, 1);
        rd_chk("R2", 0, 0, 64'd4);

        // R3 supervisor, bit 61 vs bit 59
        cur_req = "R3";
        wr(1, 2, 64'h2000_0000_0000_0000);
        pulse(1, 2);
        rd_chk("R3", 1, 0, 64'd0);
        virt = 1; pulse(1, 2);
        rd_chk("R3", 1, 0, 64'd2);
        wr(1, 2, 64'h0800_0000_0000_0000);
        pulse(1, 1);
        rd_chk("R3", 1, 0, 64'd2);
        virt = 0; pulse(1, 1);
        rd_chk("R3", 1, 0, 64'd3);

        // R4 user, bit 60 vs bit 58, reserved level
        cur_req = "R4"; priv = 2'b00;
        wr(2, 2, 64'h1000_0000_0000_0000);
        pulse(2, 1);
        rd_chk("R4", 2, 0, 64'd0);
        virt = 1; pulse(2, 1);
        rd_chk("R4", 2, 0, 64'd1);
        wr(2, 2, 64'h0400_0000_0000_0000);
        pulse(2, 1);
        rd_chk("R4", 2, 0, 64'd1);
        virt = 0; pulse(2, 1);
        rd_chk("R4", 2, 0, 64'd2);
        wr(2, 2, 64'h7C00_0000_0000_0000);
        priv = 2'b10; pulse(2, 1);
        rd_chk("R4", 2, 0, 64'd3);

        // R5 global mask
        cur_req = "R5"; priv = 2'b11;
        inh_mask[3] = 1; pulse(3, 3);
        rd_chk("R5", 3, 0, 64'd0);
        inh_mask[3] = 0; pulse(3, 1);
        rd_chk("R5", 3, 0, 64'd1);

        // R6 / R9 wrap with flag clear
        cur_req = "R9";
        wr(0, 2, 64'd0);
        wr(0, 0, ONES);
        pulse(0, 1);
        rd_chk("R6", 0, 0, 64'd0);
        chk("R9 irq", {63'd0, ovf_irq}, 64'd1);
        rd_chk("R9", 0, 2, 64'h8000_0000_0000_0000);

        // R10 hold then clear
        cur_req = "R10";
        repeat (3) tick();
        chk("R10 hold", {63'd0, ovf_irq}, 64'd1);
        irq_clear = 1; tick(); irq_clear = 0;
        chk("R10 clear", {63'd0, ovf_irq}, 64'd0);

        // R9 wrap with flag already set
        cur_req = "R9";
        wr(0, 0, ONES);
        pulse(0, 1);
        rd_chk("R9", 0, 0, 64'd0);
        chk("R9 no irq", {63'd0, ovf_irq}, 64'd0);

        // R11 re-arm
        cur_req = "R11";
        wr(0, 2, 64'd0);
        wr(0, 0, ONES);
        pulse(0, 1);
        chk("R11 irq", {63'd0, ovf_irq}, 64'd1);

        // R10 clear meeting a new overflow
        cur_req = "R10";
        wr(0, 2, 64'd0);
        wr(0, 0, ONES);
        evt_strobe[0] = 1; irq_clear = 1;
        tick();
        evt_strobe[0] = 0; irq_clear = 0;
        chk("R10 clash", {63'd0, ovf_irq}, 64'd1);
        irq_clear = 1; tick(); irq_clear = 0;
        chk("R10 clear2", {63'd0, ovf_irq}, 64'd0);

        // R12 write beats increment
        cur_req = "R12";
        wr_en = 1; wr_idx = 1; wr_sel = 0; wr_data = 64'd100; evt_strobe[1] = 1;
        tick();
        wr_en = 0; evt_strobe[1] = 0;
        rd_chk("R12", 1, 0, 64'd100);
        pulse(1, 1);
        rd_chk("R12", 1, 0, 64'd101);

        // R7 split increment in 32-bit view
        cur_req = "R7"; mode32 = 1;
        wr(3, 0, 64'hFFFF_FFFE);
        wr(3, 1, 64'd5);
        pulse(3, 1);
        rd_chk("R7", 3, 0, 64'hFFFF_FFFF);
        rd_chk("R7", 3, 1, 64'd5);
        pulse(3, 1);
        rd_chk("R7", 3, 0, 64'hFFFF_FFFF);
        rd_chk("R7", 3, 1, 64'd6);
        wr(3, 1, 64'hFFFF_FFFF);
        pulse(3, 1);
        rd_chk("R7", 3, 0, 64'd0);
        rd_chk("R7", 3, 1, 64'd0);
        chk("R7 irq", {63'd0, ovf_irq}, 64'd1);
        irq_clear = 1; tick(); irq_clear = 0;

        // R8 control bits in the high event register
        cur_req = "R8";
        wr(3, 3, 64'h4000_0000);
        pulse(3, 2);
        rd_chk("R8", 3, 0, 64'd0);
        rd_chk("R8", 3, 2, 64'd0);
        rd_chk("R8", 3, 3, 64'h4000_0000);
        mode32 = 0;
        rd_chk("R8", 3, 2, 64'h4000_0000_0000_0000);
        wr(3, 1, 64'd77);
        wr(3, 3, 64'd0);
        rd_chk("R8", 3, 0, 64'd0);
        rd_chk("R8", 3, 1, 64'd0);
        rd_chk("R8", 3, 2, 64'h4000_0000_0000_0000);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule